// File: doc/BRIEF.md
# Flash Program Command Sequencer

This engine carries out a program (write) command on a small embedded flash array. Software sets up the command through a register port: a size code, a control word, a target byte address, a byte-enable mask, a protection bitmap and up to eight staged data words with their check bytes. A write of the value 1 to the execute register starts the command. The engine first checks every target word against the protection bitmap. It then programs the words one after another. For each word it applies a program pulse and reads the result back, and it retries within a pulse limit.

The flash array is a behavioural model inside the block. Stored bits can only be cleared: each pulse ANDs a 72-bit pattern into the addressed word, and reset returns the array to the erased, all-ones state. Two test inputs mark bits that need a second pulse before they clear, or bits that never clear. The staging registers act as live bit masks while a command runs. Once a bit reads back as cleared, its staging bit is set to one so later pulses leave it alone. When a command ends, the engine locks both protection bits, refills the staging registers with ones and clears the byte enables.

The register port is a plain single-cycle write and combinational read. It carries no valid/ready handshake, because every register write completes in the cycle it is presented. The flash read port is also combinational.

Top module: `fpgm_seq`

## Requirements
- R1: After reset, the status register (offset 0x06) reads 0, the protection register (0x04) reads 3, the byte-enable register (0x03) reads 0, every staging data and check-byte register reads all ones, the status address register (0x07) reads 0, and every flash word reads all ones.
- R2: A write of exactly 0x1 to the execute register (0x05) while idle starts a command, and status bit 0 (busy) reads 1 from the next cycle. A write of any other value to 0x05 starts nothing and changes no state.
- R3: The size code in bits [1:0] of register 0x00 selects 1, 2, 4 or 8 words (codes 0 to 3). The words are programmed at consecutive word addresses, starting from bits [AW+2:3] of the address register (0x02) and wrapping modulo the array depth. Staging slot k (data low half at 0x10+2k, high half at 0x11+2k) goes to the k-th word, and each word becomes its old value AND the programmed pattern.
- R4: Bit i of the byte-enable register enables byte i of the 72-bit word. Bits 0 to 7 cover the data bytes and bit 8 covers the check byte in bits [71:64]. A disabled byte is left unchanged.
- R5: When control bit 0 (register 0x01) is clear, each word's check byte is the XOR of its eight data bytes, taken when the command starts. When the bit is set, slot k's check byte comes from register 0x20+k.
- R6: The protection bitmap (0x04) has one bit per array half, selected by the word address MSB, and a set bit means protected. If any target word lies in a protected half, the command ends with status bits done=1, pass=0 and protection-fail (bit 3)=1, and no word is written.
- R7: A word is pulsed again until every bit it programs reads back cleared, up to PULSE_MAX pulses. A bit that clears on the last allowed pulse still passes. A word that still fails after the limit ends the command with verify-fail (bit 4)=1 and pass=0, and the words after it are not written.
- R8: Status done (bit 1) and pass (bit 2) change in the same cycle the command ends, as busy falls. Pass is 1 only when neither failure flag is set.
- R9: At the end of every command, pass or fail, the protection register reads 3, all staging data and check-byte registers read all ones, and the byte-enable register reads 0.
- R10: Register 0x07 reports the last word attempted, with the bank (word address MSB) in bit 16 and the offset within the bank in the low bits. After a protection fail it reports the base word.
- R11: While busy, all register writes (including execute) are ignored. The configuration registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; also erases the array |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 6 | Register write offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 6 | Register read offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| fl_raddr | input | AW | Flash word read address |
| fl_rdata | output | 72 | Flash word contents, check byte in [71:64] |
| tst_slow | input | 72 | Bits that clear only from the second pulse onward |
| tst_stuck | input | 72 | Bits that never clear |

## Verification
Two things can land in the same verify cycle: a retried word finally reading back correct, and the pulse counter reaching its limit. The bench builds the engine with a pulse limit of two and marks every array bit as slow, so each programmed bit clears only on the last pulse allowed. It then checks that every word passes with correct contents. The same edge also decides between verify-fail and moving on to the next word. A separate case uses a stuck bit to show that the limit fails the command, stops before the following word, and reports the failing word's address.

// File: rtl/fpgm_pkg.sv
package fpgm_pkg;

  localparam int SLOTS = 8;

  localparam logic [5:0] REG_SIZE   = 6'h00;
  localparam logic [5:0] REG_CTL    = 6'h01;
  localparam logic [5:0] REG_ADDR   = 6'h02;
  localparam logic [5:0] REG_BYTEN  = 6'h03;
  localparam logic [5:0] REG_PROT   = 6'h04;
  localparam logic [5:0] REG_EXEC   = 6'h05;
  localparam logic [5:0] REG_STAT   = 6'h06;
  localparam logic [5:0] REG_STADDR = 6'h07;

  typedef enum logic [1:0] {
    S_IDLE,
    S_CHECK,
    S_PULSE,
    S_VERIFY
  } fsm_e;

  function automatic logic [7:0] ecc_of(input logic [63:0] d);
    logic [7:0] e;
    e = 8'h00;
    for (int b = 0; b < 8; b++) e = e ^ d[b*8 +: 8];
    return e;
  endfunction

endpackage

// File: rtl/fpgm_ecc_gen.sv
module fpgm_ecc_gen
  import fpgm_pkg::*;
#(
  parameter int N = SLOTS
) (
  input  logic [N-1:0][63:0] data,
  output logic [N-1:0][7:0]  ecc
);

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign ecc[g] = ecc_of(data[g]);
  end

endmodule

// File: rtl/fpgm_prot_chk.sv
module fpgm_prot_chk
  import fpgm_pkg::*;
#(
  parameter int AW = 4,
  parameter int N  = SLOTS
) (
  input  logic [AW-1:0] base,
  input  logic [3:0]    nwords,
  input  logic [1:0]    prot,
  output logic          hit
);

  logic [AW-1:0] w;

  always_comb begin
    hit = 1'b0;
    w   = '0;
    for (int i = 0; i < N; i++) begin
      if (i < int'(nwords)) begin
        w = base + AW'(i);
        if (prot[w[AW-1]]) hit = 1'b1;
      end
    end
  end

endmodule

// File: rtl/fpgm_array.sv
module fpgm_array #(
  parameter int DEPTH = 16,
  parameter int CW    = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse_en,
  input  logic [AW-1:0] pulse_addr,
  input  logic [71:0]   pulse_word,
  input  logic [CW-1:0] pulse_num,
  input  logic [71:0]   slow_bits,
  input  logic [71:0]   stuck_bits,
  output logic [71:0]   vf_data,
  input  logic [AW-1:0] rd_addr,
  output logic [71:0]   rd_data
);

  logic [71:0] mem [DEPTH];
  logic [71:0] eff;

  // Bits held at one by the test hooks are kept out of this pulse.
  assign eff = pulse_word | stuck_bits | ((pulse_num < CW'(2)) ? slow_bits : 72'h0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (pulse_en) begin
      mem[pulse_addr] <= mem[pulse_addr] & eff;
    end
  end

  assign vf_data = mem[pulse_addr];
  assign rd_data = mem[rd_addr];

  // A pulse can clear bits but never set one.
  assert_and_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_en |=> ((mem[$past(pulse_addr)] & ~$past(vf_data)) == 72'h0));

endmodule

// File: rtl/fpgm_seq.sv
module fpgm_seq
  import fpgm_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int PULSE_MAX = 4,
  localparam int AW       = $clog2(DEPTH),
  localparam int CW       = $clog2(PULSE_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [5:0]    reg_waddr,
  input  logic [31:0]   reg_wdata,
  input  logic [5:0]    reg_raddr,
  output logic [31:0]   reg_rdata,
  input  logic [AW-1:0] fl_raddr,
  output logic [71:0]   fl_rdata,
  input  logic [71:0]   tst_slow,
  input  logic [71:0]   tst_stuck
);

  // configuration and staging
  logic [1:0]              size_q;
  logic                    ovr_q;
  logic [31:0]             addr_q;
  logic [8:0]              byten_q;
  logic [1:0]              prot_q;
  logic [SLOTS-1:0][63:0]  data_q;
  logic [SLOTS-1:0][7:0]   ecc_q;

  // status
  logic          busy_q, done_q, pass_q, fprot_q, fvfy_q;
  logic [AW-1:0] staddr_q;

  // sequencing
  fsm_e          state_q;
  logic [2:0]    slot_q;
  logic [CW-1:0] pcnt_q;

  logic [AW-1:0]          base_w, cur_w;
  logic [3:0]             n_words;
  logic                   last_slot;
  logic [71:0]            bmask, cur_word, pulse_word, vf_data, new_stage;
  logic                   word_ok, prot_hit, start;
  logic [SLOTS-1:0][7:0]  ecc_gen;

  assign base_w    = addr_q[AW+2:3];
  assign cur_w     = base_w + AW'(slot_q);
  assign n_words   = 4'd1 << size_q;
  assign last_slot = ({1'b0, slot_q} == (n_words - 4'd1));

  for (genvar b = 0; b < 9; b++) begin : g_bmask
    assign bmask[b*8 +: 8] = {8{byten_q[b]}};
  end

  assign cur_word   = {ecc_q[slot_q], data_q[slot_q]};
  assign pulse_word = cur_word | ~bmask;
  // A bit that reads back cleared needs no further pulse.
  assign new_stage  = cur_word | ~vf_data | ~bmask;
  assign word_ok    = &new_stage;

  assign start = reg_we && !busy_q && (reg_waddr == REG_EXEC) && (reg_wdata == 32'h1);

  fpgm_ecc_gen #(.N(SLOTS)) u_ecc (
    .data (data_q),
    .ecc  (ecc_gen)
  );

  fpgm_prot_chk #(.AW(AW), .N(SLOTS)) u_prot (
    .base   (base_w),
    .nwords (n_words),
    .prot   (prot_q),
    .hit    (prot_hit)
  );

  fpgm_array #(.DEPTH(DEPTH), .CW(CW)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .pulse_en   (state_q == S_PULSE),
    .pulse_addr (cur_w),
    .pulse_word (pulse_word),
    .pulse_num  (pcnt_q),
    .slow_bits  (tst_slow),
    .stuck_bits (tst_stuck),
    .vf_data    (vf_data),
    .rd_addr    (fl_raddr),
    .rd_data    (fl_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q   <= '0;
      ovr_q    <= 1'b0;
      addr_q   <= '0;
      byten_q  <= '0;
      prot_q   <= 2'b11;
      data_q   <= '1;
      ecc_q    <= '1;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
      fprot_q  <= 1'b0;
      fvfy_q   <= 1'b0;
      staddr_q <= '0;
      state_q  <= S_IDLE;
      slot_q   <= '0;
      pcnt_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (reg_we) begin
            if (reg_waddr == REG_SIZE)  size_q  <= reg_wdata[1:0];
            if (reg_waddr == REG_CTL)   ovr_q   <= reg_wdata[0];
            if (reg_waddr == REG_ADDR)  addr_q  <= reg_wdata;
            if (reg_waddr == REG_BYTEN) byten_q <= reg_wdata[8:0];
            if (reg_waddr == REG_PROT)  prot_q  <= reg_wdata[1:0];
            if (reg_waddr[5:4] == 2'b01) begin
              if (reg_waddr[0]) data_q[reg_waddr[3:1]][63:32] <= reg_wdata;
              else              data_q[reg_waddr[3:1]][31:0]  <= reg_wdata;
            end
            if (reg_waddr[5:3] == 3'b100) ecc_q[reg_waddr[2:0]] <= reg_wdata[7:0];
          end
          if (start) begin
            busy_q  <= 1'b1;
            done_q  <= 1'b0;
            pass_q  <= 1'b0;
            fprot_q <= 1'b0;
            fvfy_q  <= 1'b0;
            slot_q  <= '0;
            pcnt_q  <= CW'(1);
            state_q <= S_CHECK;
            if (!ovr_q) ecc_q <= ecc_gen;
          end
        end
        S_CHECK: begin
          if (prot_hit) begin
            staddr_q <= base_w;
            fprot_q  <= 1'b1;
            busy_q   <= 1'b0;
            done_q   <= 1'b1;
            pass_q   <= 1'b0;
            prot_q   <= 2'b11;
            byten_q  <= '0;
            data_q   <= '1;
            ecc_q    <= '1;
            state_q  <= S_IDLE;
          end else begin
            state_q <= S_PULSE;
          end
        end
        S_PULSE: begin
          state_q <= S_VERIFY;
        end
        S_VERIFY: begin
          {ecc_q[slot_q], data_q[slot_q]} <= new_stage;
          staddr_q <= cur_w;
          if (word_ok && !last_slot) begin
            slot_q  <= slot_q + 3'd1;
            pcnt_q  <= CW'(1);
            state_q <= S_PULSE;
          end else if (!word_ok && (pcnt_q != CW'(PULSE_MAX))) begin
            pcnt_q  <= pcnt_q + CW'(1);
            state_q <= S_PULSE;
          end else begin
            fvfy_q  <= !word_ok;
            pass_q  <= word_ok;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            prot_q  <= 2'b11;
            byten_q <= '0;
            data_q  <= '1;
            ecc_q   <= '1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_rdata = 32'h0;
    case (reg_raddr)
      REG_SIZE:   reg_rdata = {30'h0, size_q};
      REG_CTL:    reg_rdata = {31'h0, ovr_q};
      REG_ADDR:   reg_rdata = addr_q;
      REG_BYTEN:  reg_rdata = {23'h0, byten_q};
      REG_PROT:   reg_rdata = {30'h0, prot_q};
      REG_STAT:   reg_rdata = {27'h0, fvfy_q, fprot_q, pass_q, done_q, busy_q};
      REG_STADDR: reg_rdata = {15'h0, staddr_q[AW-1], 16'(staddr_q[AW-2:0])};
      default: begin
        if (reg_raddr[5:4] == 2'b01)
          reg_rdata = reg_raddr[0] ? data_q[reg_raddr[3:1]][63:32]
                                   : data_q[reg_raddr[3:1]][31:0];
        else if (reg_raddr[5:3] == 3'b100)
          reg_rdata = {24'h0, ecc_q[reg_raddr[2:0]]};
      end
    endcase
  end

  assert_busy_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);

  assert_no_pulse_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PULSE) |-> !prot_q[cur_w[AW-1]]);

  assert_pulse_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PULSE || state_q == S_VERIFY) |->
      (pcnt_q >= CW'(1) && pcnt_q <= CW'(PULSE_MAX)));

  assert_flags_same_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (!busy_q && (pass_q != (fprot_q || fvfy_q))));

  assert_relock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (prot_q == 2'b11 && byten_q == 9'h0));

  assert_frozen_cfg_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(addr_q) && $stable(size_q) && $stable(ovr_q)));

endmodule

// File: tb/fpgm_seq_tb.sv
`timescale 1ns/100ps
module fpgm_seq_tb;

  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [5:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic [AW-1:0] fl_raddr = '0;
  logic [71:0] fl_rdata;
  logic [71:0] tst_slow = '0;
  logic [71:0] tst_stuck = '0;

  int total = 0;
  int bad = 0;
  logic [71:0] mdl [DEPTH];

  always #2 clk = ~clk;

  fpgm_seq #(.DEPTH(DEPTH), .PULSE_MAX(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .fl_raddr(fl_raddr), .fl_rdata(fl_rdata), .tst_slow(tst_slow),
    .tst_stuck(tst_stuck)
  );

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int s);
    logic [63:0] z;
    z = (64'h1 << (s % 64)) | (64'h1 << ((s*13+5) % 64)) | (64'h1 << ((s*29+11) % 64));
    return ~z;
  endfunction

  function automatic logic [7:0] epat(input int s);
    return 8'hFF ^ (8'h1 << (s % 8)) ^ (8'h1 << ((s*3+1) % 8));
  endfunction

  function automatic logic [7:0] xecc(input logic [63:0] d);
    logic [7:0] e = 8'h00;
    for (int b = 0; b < 8; b++) e = e ^ d[b*8 +: 8];
    return e;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) mdl[i] = '1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    reg_raddr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic setup(input int sz, input int bw, input bit ovr, input logic [8:0] be,
                       input logic [1:0] pr, input int seed);
    logic [63:0] d;
    wr(6'h00, 32'(sz));
    wr(6'h01, {31'h0, ovr});
    wr(6'h02, 32'(bw * 8));
    wr(6'h03, {23'h0, be});
    wr(6'h04, {30'h0, pr});
    for (int k = 0; k < 8; k++) begin
      d = pat(seed + k);
      wr(6'(16 + 2*k), d[31:0]);
      wr(6'(17 + 2*k), d[63:32]);
      wr(6'(32 + k), {24'h0, epat(seed + k)});
    end
  endtask

  // Starts the command, checks busy, waits for done; checks R8 ordering.
  task automatic exec_wait(output logic [31:0] st);
    logic [31:0] prev;
    int n;
    wr(6'h05, 32'h1);
    rd(6'h06, st);
    chk("R2 busy after exec", {71'h0, st[0]}, 72'h1);
    prev = st;
    n = 0;
    while (!st[1] && n < 200) begin
      @(negedge clk);
      prev = st;
      rd(6'h06, st);
      n++;
    end
    if (n >= 200) chk("R8 done timeout", 72'h0, 72'h1);
    chk("R8 pass low before done", {71'h0, prev[2]}, 72'h0);
    chk("R8 busy low at done", {71'h0, st[0]}, 72'h0);
  endtask

  task automatic model_prog(input int sz, input int bw, input bit ovr, input logic [8:0] be,
                            input int seed);
    logic [71:0] t, bm;
    int w;
    for (int b = 0; b < 9; b++) bm[b*8 +: 8] = {8{be[b]}};
    for (int k = 0; k < (1 << sz); k++) begin
      w = (bw + k) % DEPTH;
      t = {ovr ? epat(seed + k) : xecc(pat(seed + k)), pat(seed + k)};
      mdl[w] = mdl[w] & (t | ~bm);
    end
  endtask

  task automatic chk_flash(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      fl_raddr = AW'(a);
      #1;
      chk(req, fl_rdata, mdl[a]);
    end
  endtask

  task automatic chk_cleared();
    logic [31:0] v;
    rd(6'h04, v); chk("R9 prot relocked", 72'(v), 72'h3);
    rd(6'h03, v); chk("R9 byten cleared", 72'(v), 72'h0);
    rd(6'h1F, v); chk("R9 data ones", 72'(v), 72'hFFFF_FFFF);
    rd(6'h10, v); chk("R9 data ones", 72'(v), 72'hFFFF_FFFF);
    rd(6'h20, v); chk("R9 ecc ones", 72'(v), 72'hFF);
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    report();
  end

  initial begin
    logic [31:0] v, st;
    int bws [4] = '{0, 5, 6, 13};
    logic [8:0] bes [5] = '{9'h001, 9'h0F0, 9'h100, 9'h0AA, 9'h155};
    logic [71:0] e72;
    int cs;

    // R1 reset state
    do_reset();
    rd(6'h06, v); chk("R1 status", 72'(v), 72'h0);
    rd(6'h04, v); chk("R1 prot", 72'(v), 72'h3);
    rd(6'h03, v); chk("R1 byten", 72'(v), 72'h0);
    rd(6'h17, v); chk("R1 data", 72'(v), 72'hFFFF_FFFF);
    rd(6'h27, v); chk("R1 ecc", 72'(v), 72'hFF);
    rd(6'h07, v); chk("R1 staddr", 72'(v), 72'h0);
    chk_flash("R1 erased");

    // R3 R5 R10 sweep: size x base x check-byte source
    cs = 0;
    for (int sz = 0; sz < 4; sz++)
      for (int bi = 0; bi < 4; bi++)
        for (int ov = 0; ov < 2; ov++) begin
          int w;
          do_reset();
          setup(sz, bws[bi], ov[0], 9'h1FF, 2'b00, cs * 8);
          exec_wait(st);
          chk("R3 status pass", 72'(st), 72'h6);
          model_prog(sz, bws[bi], ov[0], 9'h1FF, cs * 8);
          chk_flash(ov[0] ? "R5 override words" : "R3 R5 generated words");
          w = (bws[bi] + (1 << sz) - 1) % DEPTH;
          rd(6'h07, v);
          chk("R10 last word", 72'(v), 72'(((w >> 3) << 16) | (w & 7)));
          chk_cleared();
          cs++;
        end

    // R4 byte-enable sweep
    foreach (bes[i]) begin
      do_reset();
      setup(0, 2, 1'b1, bes[i], 2'b00, 100 + i);
      exec_wait(st);
      chk("R4 status", 72'(st), 72'h6);
      model_prog(0, 2, 1'b1, bes[i], 100 + i);
      chk_flash("R4 masked bytes");
    end

    // R6 protection: 4 words from 6 reach bank 1, which is locked
    do_reset();
    setup(2, 6, 1'b0, 9'h1FF, 2'b10, 200);
    exec_wait(st);
    chk("R6 prot fail status", 72'(st), 72'hA);
    chk_flash("R6 nothing written");
    rd(6'h07, v); chk("R10 base on prot fail", 72'(v), 72'h6);
    chk_cleared();
    do_reset();
    setup(0, 3, 1'b0, 9'h1FF, 2'b01, 210);
    exec_wait(st);
    chk("R6 bank0 lock", 72'(st), 72'hA);
    chk_flash("R6 nothing written");

    // R7 every bit clears only on the final allowed pulse
    do_reset();
    tst_slow = '1;
    setup(3, 4, 1'b0, 9'h1FF, 2'b00, 300);
    exec_wait(st);
    chk("R7 pass at limit", 72'(st), 72'h6);
    model_prog(3, 4, 1'b0, 9'h1FF, 300);
    chk_flash("R7 slow words");
    tst_slow = '0;

    // R7 stuck bit: word 3 fails, word 4 untouched
    do_reset();
    tst_stuck = 72'h1;
    setup(1, 3, 1'b1, 9'h1FF, 2'b00, 400);
    wr(6'h10, 32'hFFFF_FFFE);
    exec_wait(st);
    chk("R7 verify fail", 72'(st), 72'h12);
    e72 = {epat(400), pat(400)};
    e72[31:0] = 32'hFFFF_FFFE;
    mdl[3] = e72 | 72'h1;
    chk_flash("R7 stop after failing word");
    rd(6'h07, v); chk("R10 failing word", 72'(v), 72'h3);
    chk_cleared();
    tst_stuck = '0;

    // R2 wrong execute values
    do_reset();
    setup(0, 1, 1'b0, 9'h0FF, 2'b00, 500);
    wr(6'h05, 32'h2);
    rd(6'h06, v); chk("R2 exec 2 ignored", 72'(v), 72'h0);
    wr(6'h05, 32'h101);
    rd(6'h06, v); chk("R2 exec 0x101 ignored", 72'(v), 72'h0);
    rd(6'h03, v); chk("R2 byten kept", 72'(v), 72'h0FF);
    chk_flash("R2 no write");

    // R11 writes while busy
    do_reset();
    tst_slow = '1;
    setup(3, 0, 1'b0, 9'h1FF, 2'b00, 600);
    wr(6'h05, 32'h1);
    wr(6'h02, 32'h40);
    wr(6'h01, 32'h1);
    wr(6'h00, 32'h0);
    wr(6'h05, 32'h1);
    st = 0;
    for (int n = 0; n < 200 && !st[1]; n++) begin
      @(negedge clk);
      rd(6'h06, st);
    end
    chk("R11 status", 72'(st), 72'h6);
    rd(6'h02, v); chk("R11 addr kept", 72'(v), 72'h0);
    rd(6'h01, v); chk("R11 ctl kept", 72'(v), 72'h0);
    rd(6'h00, v); chk("R11 size kept", 72'(v), 72'h3);
    model_prog(3, 0, 1'b0, 9'h1FF, 600);
    chk_flash("R11 words");
    repeat (3) @(negedge clk);
    rd(6'h06, v); chk("R11 exec ignored", 72'(v), 72'h6);
    tst_slow = '0;

    report();
  end

endmodule